// File: doc/BRIEF.md
# Address-Range Memory Event Histogram Monitor

This block sits next to a cache controller and observes one memory-access event per clock. Each event carries an address, a write flag and a miss flag. The block sorts every event into one of four kinds. It then counts the event against programmed address windows, so that accesses to individual data structures can be measured without software running during the measurement.

The block has two modes. In counter mode, a small bank of counters is active. Each counter has its own address window and its own event kind, so several data structures can be measured at once. In histogram mode, one address window is cut into bins of equal width, and each bin counts the events whose kinds are enabled in a mask. The bin width is a whole number of cache lines.

Software uses the block in this order:
1. Write the configuration while the block is idle.
2. Start the block when the code region of interest is entered.
3. Stop it when the region is left.
4. Read each counter or bin back through an indexed port that has one cycle of latency.

Top module: `memEventHistMon`

## Requirements
- R1: Bit 0 of configuration register 0 selects the mode: 0 is counter mode and 1 is histogram mode. In counter mode only the range counters change. In histogram mode only the bins change.
- R2: The event kind is the 2-bit value {evWrite, evMiss}: 0 is a read hit, 1 a read miss, 2 a write hit and 3 a write miss.
- R3: Range counter i is configured through registers 16+4i (window base), 16+4i+1 (window end, exclusive) and 16+4i+2 (kind, bits 1:0). It counts an event when base <= address < end and the event kind equals its kind. All counters are evaluated independently on the same event.
- R4: Histogram mode is configured through registers 1 (base), 2 (end, exclusive), 3 (kind mask: bit k enables kind k) and 4 (line multiple). The bin index is ((address - base) / LINE_BYTES) / multiple. A multiple of 0 behaves as 1. An event is counted only if the mask bit for its kind is set.
- R5: In histogram mode, an event is ignored if its address is below the base, at or above the end, or if its bin index is NUM_BINS or more.
- R6: startCmd sets running from the next cycle, and stopCmd clears it from the next cycle. If both are asserted together, stop wins. An event is counted when running is high in the cycle the event is presented, and the count becomes visible in the following cycle.
- R7: rdData is registered. It shows the entry chosen in the previous cycle by rdBank (0 selects the range counters, 1 the bins) and rdIdx. It reads 0 if running was high in that cycle, and it reads 0 for a range-counter index of NUM_CTR or above.
- R8: Every counter and bin is CNT_W bits wide and holds at its all-ones value instead of wrapping.
- R9: clearCmd zeroes every counter and every bin in one cycle, whether the block is running or not. It takes priority over an event in the same cycle.
- R10: Configuration writes (cfgWe) are ignored while running is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | CFG_AW | Configuration register address |
| cfgWData | input | ADDR_W | Configuration write data |
| startCmd | input | 1 | Start counting |
| stopCmd | input | 1 | Stop counting |
| clearCmd | input | 1 | Zero all counters and bins |
| evValid | input | 1 | Access event strobe |
| evAddr | input | ADDR_W | Address of the access |
| evWrite | input | 1 | Access is a write |
| evMiss | input | 1 | Access missed the cache |
| rdBank | input | 1 | Readout bank: 0 range counters, 1 bins |
| rdIdx | input | IDX_W | Readout index |
| rdData | output | CNT_W | Selected count, one cycle later |
| running | output | 1 | Monitor is counting |

## Verification
The bench probes each window edge: one byte below a base, the base itself, the last byte before an end, and the end itself. A design with an inclusive end, or a signed compare, would count an event that must be dropped.

It places events on both sides of a bin boundary, with a multiple above one and with a multiple of zero. A wrong shift or divide would move events into a neighbouring bin, and an unguarded zero multiple would produce garbage bins. Events that would land past the last bin are checked as dropped.

Seventy events are driven into a single bin. A wrapping counter would read back a small number instead of the all-ones value.

Three cycle-level cases are also covered:
- A clear in the same cycle as an event. The count must end at zero.
- An event in the start cycle and another in the stop cycle. Only the one in the stop cycle counts.
- A configuration write while running. It must leave the mode unchanged.

// File: rtl/hist_mon_pkg.sv
package hist_mon_pkg;

  typedef enum logic [1:0] {
    KIND_RD_HIT  = 2'd0,
    KIND_RD_MISS = 2'd1,
    KIND_WR_HIT  = 2'd2,
    KIND_WR_MISS = 2'd3
  } evKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic countStatic;
    logic countHist;
    logic clearAll;
    logic readGate;
  } ctrlStrobe_t;

  localparam int REG_MODE       = 0;
  localparam int REG_HIST_BASE  = 1;
  localparam int REG_HIST_END   = 2;
  localparam int REG_HIST_MASK  = 3;
  localparam int REG_BIN_MULT   = 4;
  localparam int REG_CTR_FIRST  = 16;
  localparam int REG_CTR_STRIDE = 4;
  localparam int CTR_FLD_BASE   = 0;
  localparam int CTR_FLD_END    = 1;
  localparam int CTR_FLD_KIND   = 2;

endpackage

// File: rtl/histMonSatCounter.sv
module histMonSatCounter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (inc && (cnt != CNT_MAX)) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/histMonCtrl.sv
module histMonCtrl
  import hist_mon_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_CTR = 4,
  parameter int MULT_W  = 8,
  parameter int CFG_AW  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [ADDR_W-1:0] cfgWData,
  input  logic              startCmd,
  input  logic              stopCmd,
  input  logic              clearCmd,
  input  logic              evValid,
  output logic              running,
  output ctrlStrobe_t       strobe,
  output logic              modeDyn,
  output logic [ADDR_W-1:0] histBase,
  output logic [ADDR_W-1:0] histEnd,
  output logic [3:0]        histMask,
  output logic [MULT_W-1:0] binMult,
  output logic [ADDR_W-1:0] ctrBase [NUM_CTR],
  output logic [ADDR_W-1:0] ctrEnd  [NUM_CTR],
  output logic [1:0]        ctrKind [NUM_CTR]
);

  logic cfgOpen;
  assign cfgOpen = cfgWe && !running;

  // run state: stop has priority over start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
    end else if (stopCmd) begin
      running <= 1'b0;
    end else if (startCmd) begin
      running <= 1'b1;
    end
  end

  // global configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeDyn  <= 1'b0;
      histBase <= '0;
      histEnd  <= '0;
      histMask <= '0;
      binMult  <= MULT_W'(1);
    end else if (cfgOpen) begin
      if (cfgAddr == CFG_AW'(REG_MODE))      modeDyn  <= cfgWData[0];
      if (cfgAddr == CFG_AW'(REG_HIST_BASE)) histBase <= cfgWData;
      if (cfgAddr == CFG_AW'(REG_HIST_END))  histEnd  <= cfgWData;
      if (cfgAddr == CFG_AW'(REG_HIST_MASK)) histMask <= cfgWData[3:0];
      if (cfgAddr == CFG_AW'(REG_BIN_MULT))  binMult  <= cfgWData[MULT_W-1:0];
    end
  end

  // per-counter window registers
  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctrCfg
    localparam int REG_B = REG_CTR_FIRST + REG_CTR_STRIDE * i;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctrBase[i] <= '0;
        ctrEnd[i]  <= '0;
        ctrKind[i] <= '0;
      end else if (cfgOpen) begin
        if (cfgAddr == CFG_AW'(REG_B + CTR_FLD_BASE)) ctrBase[i] <= cfgWData;
        if (cfgAddr == CFG_AW'(REG_B + CTR_FLD_END))  ctrEnd[i]  <= cfgWData;
        if (cfgAddr == CFG_AW'(REG_B + CTR_FLD_KIND)) ctrKind[i] <= cfgWData[1:0];
      end
    end
  end

  always_comb begin
    strobe.clearAll    = clearCmd;
    strobe.countStatic = running && evValid && !modeDyn && !clearCmd;
    strobe.countHist   = running && evValid &&  modeDyn && !clearCmd;
    strobe.readGate    = running;
  end

endmodule

// File: rtl/histMonDatapath.sv
module histMonDatapath
  import hist_mon_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_CTR    = 4,
  parameter int NUM_BINS   = 32,
  parameter int CNT_W      = 32,
  parameter int LINE_BYTES = 64,
  parameter int MULT_W     = 8,
  parameter int IDX_W      = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] evAddr,
  input  logic              evWrite,
  input  logic              evMiss,
  input  logic [ADDR_W-1:0] histBase,
  input  logic [ADDR_W-1:0] histEnd,
  input  logic [3:0]        histMask,
  input  logic [MULT_W-1:0] binMult,
  input  logic [ADDR_W-1:0] ctrBase [NUM_CTR],
  input  logic [ADDR_W-1:0] ctrEnd  [NUM_CTR],
  input  logic [1:0]        ctrKind [NUM_CTR],
  input  logic              rdBank,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [CNT_W-1:0]  rdData
);

  localparam int LINE_SH = $clog2(LINE_BYTES);

  evKind_e          evKind;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] lineIdx;
  logic [ADDR_W-1:0] multWide;
  logic [ADDR_W-1:0] binWide;
  logic              histHit;
  logic [CNT_W-1:0]  ctrCnt  [NUM_CTR];
  logic [CNT_W-1:0]  binCnt  [NUM_BINS];
  logic [CNT_W-1:0]  readSel;

  assign evKind = evKind_e'({evWrite, evMiss});

  // bin index: line offset divided by the line multiple (0 acts as 1)
  always_comb begin
    offset   = evAddr - histBase;
    lineIdx  = offset >> LINE_SH;
    multWide = (binMult == '0) ? ADDR_W'(1) : ADDR_W'(binMult);
    binWide  = lineIdx / multWide;
    histHit  = (evAddr >= histBase) && (evAddr < histEnd)
            && (binWide < ADDR_W'(NUM_BINS)) && histMask[evKind];
  end

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_rangeCtr
    logic hit;
    assign hit = strobe.countStatic && (evAddr >= ctrBase[i])
              && (evAddr < ctrEnd[i]) && (evKind == evKind_e'(ctrKind[i]));
    histMonSatCounter #(.CNT_W(CNT_W)) u_cnt (
      .clk (clk),
      .rstN(rstN),
      .clr (strobe.clearAll),
      .inc (hit),
      .cnt (ctrCnt[i])
    );
  end

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    logic hit;
    assign hit = strobe.countHist && histHit && (binWide == ADDR_W'(b));
    histMonSatCounter #(.CNT_W(CNT_W)) u_cnt (
      .clk (clk),
      .rstN(rstN),
      .clr (strobe.clearAll),
      .inc (hit),
      .cnt (binCnt[b])
    );
  end

  always_comb begin
    readSel = '0;
    if (rdBank) begin
      for (int b = 0; b < NUM_BINS; b++) begin
        if (rdIdx == IDX_W'(b)) readSel = binCnt[b];
      end
    end else begin
      for (int i = 0; i < NUM_CTR; i++) begin
        if (rdIdx == IDX_W'(i)) readSel = ctrCnt[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else begin
      rdData <= strobe.readGate ? '0 : readSel;
    end
  end

endmodule

// File: rtl/memEventHistMon.sv
module memEventHistMon
  import hist_mon_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_CTR    = 4,
  parameter int NUM_BINS   = 32,
  parameter int CNT_W      = 32,
  parameter int LINE_BYTES = 64,
  parameter int MULT_W     = 8,
  parameter int CFG_AW     = 6,
  localparam int IDX_W     = $clog2((NUM_BINS > NUM_CTR) ? NUM_BINS : NUM_CTR)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [ADDR_W-1:0] cfgWData,
  input  logic              startCmd,
  input  logic              stopCmd,
  input  logic              clearCmd,
  input  logic              evValid,
  input  logic [ADDR_W-1:0] evAddr,
  input  logic              evWrite,
  input  logic              evMiss,
  input  logic              rdBank,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [CNT_W-1:0]  rdData,
  output logic              running
);

  ctrlStrobe_t       strobe;
  logic              modeDyn;
  logic [ADDR_W-1:0] histBase;
  logic [ADDR_W-1:0] histEnd;
  logic [3:0]        histMask;
  logic [MULT_W-1:0] binMult;
  logic [ADDR_W-1:0] ctrBase [NUM_CTR];
  logic [ADDR_W-1:0] ctrEnd  [NUM_CTR];
  logic [1:0]        ctrKind [NUM_CTR];

  histMonCtrl #(
    .ADDR_W (ADDR_W),
    .NUM_CTR(NUM_CTR),
    .MULT_W (MULT_W),
    .CFG_AW (CFG_AW)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWe   (cfgWe),
    .cfgAddr (cfgAddr),
    .cfgWData(cfgWData),
    .startCmd(startCmd),
    .stopCmd (stopCmd),
    .clearCmd(clearCmd),
    .evValid (evValid),
    .running (running),
    .strobe  (strobe),
    .modeDyn (modeDyn),
    .histBase(histBase),
    .histEnd (histEnd),
    .histMask(histMask),
    .binMult (binMult),
    .ctrBase (ctrBase),
    .ctrEnd  (ctrEnd),
    .ctrKind (ctrKind)
  );

  histMonDatapath #(
    .ADDR_W    (ADDR_W),
    .NUM_CTR   (NUM_CTR),
    .NUM_BINS  (NUM_BINS),
    .CNT_W     (CNT_W),
    .LINE_BYTES(LINE_BYTES),
    .MULT_W    (MULT_W),
    .IDX_W     (IDX_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .evAddr  (evAddr),
    .evWrite (evWrite),
    .evMiss  (evMiss),
    .histBase(histBase),
    .histEnd (histEnd),
    .histMask(histMask),
    .binMult (binMult),
    .ctrBase (ctrBase),
    .ctrEnd  (ctrEnd),
    .ctrKind (ctrKind),
    .rdBank  (rdBank),
    .rdIdx   (rdIdx),
    .rdData  (rdData)
  );

endmodule

// File: rtl/memEventHistMonChk.sv
module memEventHistMonChk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int MULT_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              startCmd,
  input logic              stopCmd,
  input logic              clearCmd,
  input logic              running,
  input logic [CNT_W-1:0]  rdData,
  input logic              modeDyn,
  input logic [ADDR_W-1:0] histBase,
  input logic [MULT_W-1:0] binMult
);

  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    (startCmd && !stopCmd) |=> running); // R6

  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    stopCmd |=> !running); // R6

  AST_READ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    running |=> (rdData == '0)); // R7

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    running |=> ($stable(modeDyn) && $stable(histBase) && $stable(binMult))); // R10

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    (clearCmd && !running && !startCmd) |=> ##1 (rdData == '0)); // R9

endmodule

bind memEventHistMon memEventHistMonChk #(
  .ADDR_W(ADDR_W),
  .CNT_W (CNT_W),
  .MULT_W(MULT_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .startCmd(startCmd),
  .stopCmd (stopCmd),
  .clearCmd(clearCmd),
  .running (running),
  .rdData  (rdData),
  .modeDyn (modeDyn),
  .histBase(histBase),
  .binMult (binMult)
);

// File: tb/test_memEventHistMon.sv
`timescale 1ns/1ps
module test_memEventHistMon;

  localparam int AW = 32;
  localparam int NC = 4;
  localparam int NB = 32;
  localparam int CW = 6;
  localparam int LB = 64;
  localparam int MW = 8;
  localparam int CA = 6;
  localparam int IW = 5;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 0;
  logic rstN = 0;
  logic cfgWe = 0;
  logic [CA-1:0] cfgAddr = '0;
  logic [AW-1:0] cfgWData = '0;
  logic startCmd = 0, stopCmd = 0, clearCmd = 0;
  logic evValid = 0;
  logic [AW-1:0] evAddr = '0;
  logic evWrite = 0, evMiss = 0;
  logic rdBank = 0;
  logic [IW-1:0] rdIdx = '0;
  logic [CW-1:0] rdData;
  logic running;

  always #4 clk = ~clk;

  memEventHistMon #(
    .ADDR_W(AW), .NUM_CTR(NC), .NUM_BINS(NB), .CNT_W(CW),
    .LINE_BYTES(LB), .MULT_W(MW), .CFG_AW(CA)
  ) i_memEventHistMon (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWData(cfgWData),
    .startCmd(startCmd), .stopCmd(stopCmd), .clearCmd(clearCmd),
    .evValid(evValid), .evAddr(evAddr), .evWrite(evWrite), .evMiss(evMiss),
    .rdBank(rdBank), .rdIdx(rdIdx), .rdData(rdData), .running(running)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string curReq = "R6";

  // behavioural reference state
  int unsigned mCtr [NC];
  int unsigned mHist[NB];
  bit          mRun;
  bit          mMode;
  logic [AW-1:0] mHB, mHE;
  logic [3:0]  mMask;
  int unsigned mMult;
  logic [AW-1:0] mCB [NC];
  logic [AW-1:0] mCE [NC];
  int unsigned mCK [NC];

  task automatic check(bit ok, string req, longint act, longint exp, string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < NC; i++) begin mCtr[i] = 0; mCB[i] = 0; mCE[i] = 0; mCK[i] = 0; end
    for (int b = 0; b < NB; b++) mHist[b] = 0;
    mRun = 0; mMode = 0; mHB = 0; mHE = 0; mMask = 0; mMult = 1;
  endtask

  task automatic modelCfg(int a, logic [AW-1:0] d);
    if (a == 0) mMode = d[0];
    else if (a == 1) mHB = d;
    else if (a == 2) mHE = d;
    else if (a == 3) mMask = d[3:0];
    else if (a == 4) mMult = d[MW-1:0];
    else if (a >= 16 && a < 16 + 4 * NC) begin
      if ((a - 16) % 4 == 0) mCB[(a - 16) / 4] = d;
      if ((a - 16) % 4 == 1) mCE[(a - 16) / 4] = d;
      if ((a - 16) % 4 == 2) mCK[(a - 16) / 4] = d[1:0];
    end
  endtask

  task automatic modelEvent();
    int unsigned k;
    k = {evWrite, evMiss};
    if (!mMode) begin
      for (int i = 0; i < NC; i++)
        if (evAddr >= mCB[i] && evAddr < mCE[i] && k == mCK[i] && mCtr[i] < CMAX) mCtr[i]++;
    end else if (mMask[k] && evAddr >= mHB && evAddr < mHE) begin
      longint unsigned m, bin;
      m = (mMult == 0) ? 1 : mMult;
      bin = ((evAddr - mHB) / LB) / m;
      if (bin < NB && mHist[bin] < CMAX) mHist[bin]++;
    end
  endtask

  // one clock: predict, advance model, compare after the edge
  task automatic tick();
    int unsigned sel;
    int expRd;
    sel = 0;
    if (rdBank) sel = mHist[rdIdx];
    else if (rdIdx < NC) sel = mCtr[rdIdx];
    expRd = mRun ? 0 : int'(sel);
    if (cfgWe && !mRun) modelCfg(int'(cfgAddr), cfgWData);
    if (clearCmd) begin
      for (int i = 0; i < NC; i++) mCtr[i] = 0;
      for (int b = 0; b < NB; b++) mHist[b] = 0;
    end else if (evValid && mRun) modelEvent();
    if (stopCmd) mRun = 0; else if (startCmd) mRun = 1;
    @(posedge clk); #1;
    check(int'(rdData) == expRd, curReq, rdData, expRd, "rdData vs model");
    check(running == mRun, "R6", running, mRun, "running vs model");
  endtask

  task automatic cfgW(int a, logic [AW-1:0] d);
    cfgWe = 1; cfgAddr = CA'(a); cfgWData = d; tick(); cfgWe = 0;
  endtask

  task automatic ev(logic [AW-1:0] a, bit w, bit m);
    evValid = 1; evAddr = a; evWrite = w; evMiss = m; tick(); evValid = 0;
  endtask

  task automatic pulseStart(); startCmd = 1; tick(); startCmd = 0; endtask
  task automatic pulseStop();  stopCmd  = 1; tick(); stopCmd  = 0; endtask
  task automatic pulseClear(); clearCmd = 1; tick(); clearCmd = 0; endtask

  task automatic readChk(bit bank, int idx, int exp, string req);
    rdBank = bank; rdIdx = IW'(idx); tick();
    check(int'(rdData) == exp, req, rdData, exp, $sformatf("read bank %0d idx %0d", bank, idx));
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    modelReset();
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    check(rdData == 0, "R7", rdData, 0, "reset rdData");
    check(running == 0, "R6", running, 0, "reset running");

    // R3 range counters
    curReq = "R3";
    cfgW(16, 32'h1000); cfgW(17, 32'h2000); cfgW(18, 1);
    cfgW(20, 32'h1800); cfgW(21, 32'h3000); cfgW(22, 2);
    cfgW(24, 32'h0);    cfgW(25, 32'h100);  cfgW(26, 0);
    cfgW(28, 32'h4000); cfgW(29, 32'h4040); cfgW(30, 3);
    // R6 event in start cycle is not counted
    startCmd = 1; evValid = 1; evAddr = 32'h1800; evWrite = 0; evMiss = 1; tick();
    startCmd = 0; evValid = 0;
    ev(32'h1800, 0, 1); ev(32'h1900, 1, 0); ev(32'h1FFF, 0, 1);
    ev(32'h2000, 0, 1); ev(32'h0FFF, 0, 1); ev(32'h0, 0, 0);
    ev(32'hFF, 0, 0);   ev(32'h100, 0, 0);  ev(32'h403F, 1, 1);
    ev(32'h4040, 1, 1);
    // R6 event in stop cycle is counted
    stopCmd = 1; evValid = 1; evAddr = 32'h1800; evWrite = 1; evMiss = 0; tick();
    stopCmd = 0; evValid = 0;
    readChk(0, 0, 2, "R3"); readChk(0, 1, 2, "R6");
    readChk(0, 2, 2, "R2"); readChk(0, 3, 1, "R3");
    readChk(0, 5, 0, "R7");

    // R4/R5 histogram, multiple 2 -> 128-byte bins, misses only
    curReq = "R4";
    cfgW(0, 1); cfgW(1, 32'h10000); cfgW(2, 32'h11000); cfgW(3, 32'hA); cfgW(4, 2);
    pulseStart();
    ev(32'h10000, 0, 1); ev(32'h1007F, 1, 1); ev(32'h10080, 0, 1);
    ev(32'h10FFF, 1, 1); ev(32'h11000, 0, 1); ev(32'h0FFFF, 0, 1);
    ev(32'h10200, 0, 0); ev(32'h1800, 0, 1);
    pulseStop();
    readChk(1, 0, 2, "R4"); readChk(1, 1, 1, "R4"); readChk(1, 31, 1, "R5");
    readChk(1, 4, 0, "R4"); readChk(0, 0, 2, "R1");

    // R5/R4 multiple 0 behaves as 1, bins beyond the last dropped
    curReq = "R5";
    pulseClear();
    cfgW(2, 32'h20000); cfgW(4, 0);
    pulseStart();
    ev(32'h10000 + 33 * 64, 0, 1); ev(32'h10000 + 31 * 64 + 63, 0, 1);
    ev(32'h10040, 1, 1);
    pulseStop();
    readChk(1, 31, 1, "R5"); readChk(1, 1, 1, "R4");

    // R8 saturation
    curReq = "R8";
    pulseStart();
    for (int n = 0; n < 70; n++) ev(32'h10000, 0, 1);
    rdBank = 1; rdIdx = 0; tick();
    check(rdData == 0, "R7", rdData, 0, "read while running");
    pulseStop();
    readChk(1, 0, CMAX, "R8");

    // R9 clear with simultaneous event while running
    curReq = "R9";
    pulseStart();
    clearCmd = 1; evValid = 1; evAddr = 32'h10000; evWrite = 0; evMiss = 1; tick();
    clearCmd = 0; evValid = 0;
    // R10 write while running is ignored
    curReq = "R10";
    cfgW(0, 0);
    ev(32'h10000, 0, 1);
    pulseStop();
    readChk(1, 0, 1, "R10"); readChk(1, 31, 0, "R9");

    // mixed pseudo-random traffic in both modes
    curReq = "R1";
    lfsr = 16'hACE1;
    for (int pass = 0; pass < 2; pass++) begin
      pulseClear();
      cfgW(0, pass); cfgW(2, 32'h12000); cfgW(4, 3); cfgW(3, 32'h7);
      pulseStart();
      for (int n = 0; n < 300; n++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        evValid = lfsr[0]; evWrite = lfsr[1]; evMiss = lfsr[2];
        evAddr = lfsr[3] ? (32'hF000 + {20'h0, lfsr[15:4]} * 2) : {20'h0, lfsr[15:4]} * 4;
        tick();
      end
      evValid = 0;
      pulseStop();
      for (int b = 0; b < NB; b++) begin rdBank = 1; rdIdx = IW'(b); tick(); end
      for (int i = 0; i < NC; i++) begin rdBank = 0; rdIdx = IW'(i); tick(); end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule